// File: doc/BRIEF.md
# Multi-ADC Synchronized Conversion Readout

This block collects one snapshot of twelve analog channels from three external converters on every accepted tick of a periodic sampling pulse. When the run control is set and a sampling pulse arrives, it raises a shared conversion-start strobe on all three converters and waits for the common busy line to clear. It then reads the converters one after another, each under its own active-low chip select. Each converter drives two serial data lines that are read in parallel on a divided serial clock.

Every data line carries two channels. Each channel has a current result and a voltage result, each a 16-bit two's-complement word. A per-channel range bit chooses which of the two results is kept, and the kept word is cut down to its upper twelve bits with the sign preserved. All twelve values are written at once and marked by a single one-cycle valid strobe. If a sampling pulse arrives while a snapshot is still in flight, that pulse is dropped and a sticky overrun flag is raised.

Top module: `multi_adc_readout`

## Requirements
- R1: A snapshot starts only on a clock where `sample_pulse` and `conv_run` are both 1 while the block is idle. A pulse with `conv_run` at 0 produces no conversion strobe and no valid strobe.
- R2: `adc_convst` rises in the cycle after the accepted pulse and stays high for exactly CONV_CYC cycles (default 2).
- R3: No chip select goes low until `adc_busy` has been sampled low after the strobe. At most one chip select is low at a time, and the converters are selected in the order 0, 1, 2.
- R4: While a chip select is low, `adc_sclk` gives exactly 64 rising edges, and data is taken MSB first at each rising edge. `adc_sclk` is low whenever every chip select is high.
- R5: Converter k serves channels 4k to 4k+3. Its line A (`adc_dout_a[k]`) carries channels 4k+3 and 4k+2, and its line B (`adc_dout_b[k]`) carries channels 4k+1 and 4k.
- R6: On each line the 64 bits arrive as: the higher channel's current word, then its voltage word, then the lower channel's current word, then its voltage word.
- R7: `range_sel[i]` = 0 selects channel i's current word and 1 selects its voltage word. The range bits are read in the cycle the results are published.
- R8: Channel i's output is bits [15:4] of the selected word, which is an arithmetic shift right by 4 (0x8000 gives 0x800, 0xFFFF gives 0xFFF, 0x000F gives 0x000).
- R9: All twelve fields of `ch_val` (channel i at bits [12i+11:12i]) change together in the single cycle `ch_valid` is 1. `ch_valid` lasts one cycle, and `ch_val` holds otherwise.
- R10: A pulse with `conv_run` = 1 that arrives while a snapshot is in flight starts nothing and sets `overrun`. Once set, `overrun` stays 1 until reset.
- R11: After reset, `adc_convst`, `adc_sclk`, `ch_valid`, `overrun` and `ch_val` are 0, and every chip select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_run | input | 1 | Enables snapshots on sampling pulses |
| sample_pulse | input | 1 | Periodic one-cycle sampling tick |
| range_sel | input | 12 | Per-channel choice: 0 current, 1 voltage |
| adc_convst | output | 1 | Shared conversion-start strobe |
| adc_busy | input | 1 | Shared busy line from the converters |
| adc_cs_n | output | 3 | Active-low chip select per converter |
| adc_sclk | output | 1 | Serial clock, idle low |
| adc_dout_a | input | 3 | Serial line A per converter |
| adc_dout_b | input | 3 | Serial line B per converter |
| ch_val | output | 144 | Twelve 12-bit channel values |
| ch_valid | output | 1 | One-cycle strobe marking new values |
| overrun | output | 1 | Sticky flag for a dropped pulse |

## Verification
The first pattern is a ramp in which every channel, and both results of each channel, hold a different word. It is run with the range bits all 0, all 1 and mixed. A wrong line, a swapped channel or a swapped word position then shows up as a wrong value on a named channel. The second pattern places the sign and rounding boundary words 0x7FFF, 0x8000, 0xFFFF, 0x000F, 0xFFF0 and 0x800F. It separates an arithmetic cut from a logical one and from taking the wrong nibble. Random frames with busy times from zero to several dozen cycles test the wait for busy. A second pulse placed in the middle of a snapshot tests that the pulse is dropped and that the overrun flag is set and stays set.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int LINES_PER_ADC = 2;
  localparam int CH_PER_LINE   = 2;
  localparam int RES_PER_CH    = 2;
  localparam int CH_PER_ADC    = LINES_PER_ADC * CH_PER_LINE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAITB,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP,
    ST_DONE
  } rd_state_e;

endpackage

// File: rtl/adc_rd_rst_sync.sv
module adc_rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int NUM_ADC   = 3,
  parameter int SEL_W     = 2,
  parameter int CONV_CYC  = 2,
  parameter int SCLK_HALF = 1,
  parameter int BITS      = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_run,
  input  logic               sample_pulse,
  input  logic               adc_busy,
  output logic               convst,
  output logic [NUM_ADC-1:0] cs_n,
  output logic               sclk,
  output logic               sample_en,
  output logic [SEL_W-1:0]   adc_sel,
  output logic               load,
  output logic               overrun
);

  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int DW = $clog2(SCLK_HALF + 1);
  localparam int BW = $clog2(BITS);

  rd_state_e        st_q, st_d;
  logic [CW-1:0]    conv_q, conv_d;
  logic [DW-1:0]    div_q, div_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             sclk_q, sclk_d;
  logic             ovr_q, ovr_d;
  logic             accept, tick;

  assign accept = sample_pulse && conv_run;
  assign tick   = (div_q == DW'(SCLK_HALF - 1));

  always_comb begin
    st_d      = st_q;
    conv_d    = conv_q;
    div_d     = div_q;
    bit_d     = bit_q;
    idx_d     = idx_q;
    sclk_d    = sclk_q;
    ovr_d     = ovr_q;
    sample_en = 1'b0;
    load      = 1'b0;
    if (accept && (st_q != ST_IDLE)) ovr_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_CONV;
          conv_d = '0;
          idx_d  = '0;
        end
      end
      ST_CONV: begin
        if (conv_q == CW'(CONV_CYC - 1)) st_d = ST_WAITB;
        else                             conv_d = conv_q + CW'(1);
      end
      ST_WAITB: begin
        if (!adc_busy) begin
          st_d   = ST_SHIFT;
          div_d  = '0;
          bit_d  = '0;
          sclk_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          div_d  = '0;
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            sample_en = 1'b1;
            if (bit_q == BW'(BITS - 1)) st_d = ST_TAIL;
            else                        bit_d = bit_q + BW'(1);
          end
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      ST_TAIL: begin
        if (tick) begin
          div_d  = '0;
          sclk_d = 1'b0;
          st_d   = ST_GAP;
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      ST_GAP: begin
        if (idx_q == SEL_W'(NUM_ADC - 1)) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx_q + SEL_W'(1);
          st_d  = ST_SHIFT;
          div_d = '0;
          bit_d = '0;
        end
      end
      ST_DONE: begin
        load = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      conv_q <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      idx_q  <= '0;
      sclk_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      conv_q <= conv_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      sclk_q <= sclk_d;
      ovr_q  <= ovr_d;
    end
  end

  for (genvar k = 0; k < NUM_ADC; k++) begin : g_cs
    assign cs_n[k] = !(((st_q == ST_SHIFT) || (st_q == ST_TAIL)) && (idx_q == SEL_W'(k)));
  end

  assign convst  = (st_q == ST_CONV);
  assign sclk    = sclk_q;
  assign adc_sel = idx_q;
  assign overrun = ovr_q;

  AST_CONV_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst) |-> $past(sample_pulse && conv_run)); // R1
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SHIFT) && ($past(st_q) == ST_WAITB)) |-> !$past(adc_busy)); // R3
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift
  import adc_rd_pkg::*;
#(
  parameter int NUM_ADC = 3,
  parameter int SEL_W   = 2,
  parameter int BITS    = 64
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           sample_en,
  input  logic [SEL_W-1:0]                               adc_sel,
  input  logic [NUM_ADC-1:0]                             dout_a,
  input  logic [NUM_ADC-1:0]                             dout_b,
  output logic [NUM_ADC-1:0][LINES_PER_ADC-1:0][BITS-1:0] frame
);

  for (genvar k = 0; k < NUM_ADC; k++) begin : g_adc
    logic [BITS-1:0] sha_q, sha_d, shb_q, shb_d;
    logic            hit;

    assign hit = sample_en && (adc_sel == SEL_W'(k));

    always_comb begin
      sha_d = sha_q;
      shb_d = shb_q;
      if (hit) begin
        sha_d = {sha_q[BITS-2:0], dout_a[k]};
        shb_d = {shb_q[BITS-2:0], dout_b[k]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sha_q <= '0;
        shb_q <= '0;
      end else begin
        sha_q <= sha_d;
        shb_q <= shb_d;
      end
    end

    assign frame[k][1] = sha_q;
    assign frame[k][0] = shb_q;
  end

endmodule

// File: rtl/adc_rd_select.sv
module adc_rd_select
  import adc_rd_pkg::*;
#(
  parameter int NUM_ADC = 3,
  parameter int NUM_CH  = 12,
  parameter int RAW_W   = 16,
  parameter int OUT_W   = 12,
  parameter int BITS    = 64
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           load,
  input  logic [NUM_CH-1:0]                              range_sel,
  input  logic [NUM_ADC-1:0][LINES_PER_ADC-1:0][BITS-1:0] frame,
  output logic [NUM_CH*OUT_W-1:0]                        ch_val,
  output logic                                           ch_valid
);

  logic [NUM_CH-1:0][OUT_W-1:0] val_q, val_d;
  logic                         vld_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int ADC  = i / CH_PER_ADC;
    localparam int LINE = (i % CH_PER_ADC) / CH_PER_LINE;
    localparam int BASE = ((i % CH_PER_LINE) == 1) ? RES_PER_CH * RAW_W : 0;
    logic [RAW_W-1:0] cur_w, vol_w, pick_w;

    assign cur_w    = frame[ADC][LINE][BASE+RAW_W +: RAW_W];
    assign vol_w    = frame[ADC][LINE][BASE +: RAW_W];
    assign pick_w   = range_sel[i] ? vol_w : cur_w;
    assign val_d[i] = load ? pick_w[RAW_W-1 -: OUT_W] : val_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      val_q <= val_d;
      vld_q <= load;
    end
  end

  assign ch_val   = val_q;
  assign ch_valid = vld_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |=> !ch_valid); // R9
  AST_VALUES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_valid |-> $stable(ch_val)); // R9

endmodule

// File: rtl/multi_adc_readout.sv
module multi_adc_readout
  import adc_rd_pkg::*;
#(
  parameter int NUM_ADC   = 3,
  parameter int RAW_W     = 16,
  parameter int OUT_W     = 12,
  parameter int CONV_CYC  = 2,
  parameter int SCLK_HALF = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              conv_run,
  input  logic                              sample_pulse,
  input  logic [NUM_ADC*CH_PER_ADC-1:0]     range_sel,
  output logic                              adc_convst,
  input  logic                              adc_busy,
  output logic [NUM_ADC-1:0]                adc_cs_n,
  output logic                              adc_sclk,
  input  logic [NUM_ADC-1:0]                adc_dout_a,
  input  logic [NUM_ADC-1:0]                adc_dout_b,
  output logic [NUM_ADC*CH_PER_ADC*OUT_W-1:0] ch_val,
  output logic                              ch_valid,
  output logic                              overrun
);

  localparam int NUM_CH = NUM_ADC * CH_PER_ADC;
  localparam int BITS   = CH_PER_LINE * RES_PER_CH * RAW_W;
  localparam int SEL_W  = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1;

  logic             rst_n_s;
  logic             sample_en, load;
  logic [SEL_W-1:0] adc_sel;
  logic [NUM_ADC-1:0][LINES_PER_ADC-1:0][BITS-1:0] frame;

  adc_rd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  adc_rd_seq #(
    .NUM_ADC   (NUM_ADC),
    .SEL_W     (SEL_W),
    .CONV_CYC  (CONV_CYC),
    .SCLK_HALF (SCLK_HALF),
    .BITS      (BITS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .conv_run     (conv_run),
    .sample_pulse (sample_pulse),
    .adc_busy     (adc_busy),
    .convst       (adc_convst),
    .cs_n         (adc_cs_n),
    .sclk         (adc_sclk),
    .sample_en    (sample_en),
    .adc_sel      (adc_sel),
    .load         (load),
    .overrun      (overrun)
  );

  adc_rd_shift #(
    .NUM_ADC (NUM_ADC),
    .SEL_W   (SEL_W),
    .BITS    (BITS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sample_en (sample_en),
    .adc_sel   (adc_sel),
    .dout_a    (adc_dout_a),
    .dout_b    (adc_dout_b),
    .frame     (frame)
  );

  adc_rd_select #(
    .NUM_ADC (NUM_ADC),
    .NUM_CH  (NUM_CH),
    .RAW_W   (RAW_W),
    .OUT_W   (OUT_W),
    .BITS    (BITS)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (load),
    .range_sel (range_sel),
    .frame     (frame),
    .ch_val    (ch_val),
    .ch_valid  (ch_valid)
  );

endmodule

// File: tb/sim_multi_adc_readout.sv
module sim_multi_adc_readout;

  localparam int NA = 3;
  localparam int NC = 12;
  localparam int OW = 12;

  logic             clk = 1'b0;
  logic             rst_n, conv_run, sample_pulse, adc_busy, adc_convst, adc_sclk, ch_valid, overrun;
  logic [NC-1:0]    range_sel;
  logic [NA-1:0]    adc_cs_n, adc_dout_a, adc_dout_b;
  logic [NC*OW-1:0] ch_val;

  always #4 clk = ~clk;

  multi_adc_readout u0 (
    .clk(clk), .rst_n(rst_n), .conv_run(conv_run), .sample_pulse(sample_pulse),
    .range_sel(range_sel), .adc_convst(adc_convst), .adc_busy(adc_busy),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_dout_a(adc_dout_a),
    .adc_dout_b(adc_dout_b), .ch_val(ch_val), .ch_valid(ch_valid), .overrun(overrun)
  );

  int n_chk = 0, n_bad = 0, n_valid = 0, n_conv = 0, busy_len = 0;
  bit ended = 0;
  logic [15:0]      cur_m [NC];
  logic [15:0]      vol_m [NC];
  logic [NC*OW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R5 R6: converter model stream per line
  function automatic logic line_bit(int k, bit line_a, int idx);
    int hi = line_a ? 4*k + 3 : 4*k + 1;
    logic [63:0] s = {cur_m[hi], vol_m[hi], cur_m[hi-1], vol_m[hi-1]};
    return (idx < 64) ? s[63-idx] : 1'b0;
  endfunction

  // converter model and monitor, all at the falling edge
  initial begin
    int bidx [NA];
    int rises [NA];
    logic [NA-1:0]    cs_prev = '1;
    logic [NC*OW-1:0] val_prev = '0;
    logic [NC*OW-1:0] e;
    int next_adc = 0, busy_cnt = 0, cw = 0;
    logic sclk_prev = 0, conv_prev = 0, acc_prev = 0, vld_prev = 0;
    adc_busy = 0; adc_dout_a = '0; adc_dout_b = '0;
    for (int k = 0; k < NA; k++) begin bidx[k] = 0; rises[k] = 0; end
    forever begin
      @(negedge clk);
      for (int k = 0; k < NA; k++) begin
        if (cs_prev[k] && !adc_cs_n[k]) begin
          chk(k == next_adc, "R3 select order", k, next_adc);
          chk(!adc_busy, "R3 select while busy", adc_busy, 0);
          next_adc = (k + 1) % NA;
          rises[k] = 0;
        end
        if (!adc_cs_n[k] && adc_sclk && !sclk_prev) begin
          bidx[k]++;
          rises[k]++;
        end
        if (!cs_prev[k] && adc_cs_n[k]) chk(rises[k] == 64, "R4 sclk rises per select", rises[k], 64);
        if (adc_cs_n[k]) bidx[k] = 0;
        adc_dout_a[k] = line_bit(k, 1, bidx[k]);
        adc_dout_b[k] = line_bit(k, 0, bidx[k]);
      end
      cs_prev   = adc_cs_n;
      sclk_prev = adc_sclk;
      if (adc_convst) begin
        adc_busy = (busy_len > 0);
        busy_cnt = busy_len;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        adc_busy = (busy_cnt > 0);
      end else begin
        adc_busy = 0;
      end
      if (adc_convst && !conv_prev) begin
        n_conv++;
        cw = 0;
        chk(acc_prev, "R2 strobe follows accepted pulse", acc_prev, 1);
      end
      if (adc_convst) cw++;
      if (!adc_convst && conv_prev) chk(cw == 2, "R2 strobe width", cw, 2);
      conv_prev = adc_convst;
      acc_prev  = sample_pulse && conv_run;
      if (ch_valid) begin
        n_valid++;
        chk(!vld_prev, "R9 valid one cycle", vld_prev, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected valid", 1, 0);
        end else begin
          e = exp_q.pop_front();
          for (int i = 0; i < NC; i++)
            chk(ch_val[i*OW +: OW] == e[i*OW +: OW], $sformatf("R5 R6 R7 R8 ch%0d", i),
                ch_val[i*OW +: OW], e[i*OW +: OW]);
        end
      end else if (ch_val != val_prev) begin
        chk(0, "R9 values changed without valid", ch_val, val_prev);
      end
      vld_prev = ch_valid;
      val_prev = ch_val;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic frame(input logic [NC-1:0] rng, input int blen, input int extra_gap);
    int target = n_valid + 1;
    logic [NC*OW-1:0] e;
    logic [15:0] w;
    for (int i = 0; i < NC; i++) begin
      w = rng[i] ? vol_m[i] : cur_m[i];
      e[i*OW +: OW] = w[15:4];
    end
    @(posedge clk); #2;
    range_sel = rng; busy_len = blen; conv_run = 1;
    exp_q.push_back(e);
    sample_pulse = 1;
    @(posedge clk); #2;
    sample_pulse = 0;
    if (extra_gap > 0) begin
      repeat (extra_gap) @(posedge clk);
      #2; sample_pulse = 1;
      @(posedge clk); #2;
      sample_pulse = 0;
    end
    wait (n_valid >= target);
    repeat (6) @(posedge clk);
  endtask

  initial begin
    int conv_before, valid_before;
    rst_n = 0; conv_run = 0; sample_pulse = 0; range_sel = '0;
    for (int i = 0; i < NC; i++) begin cur_m[i] = '0; vol_m[i] = '0; end
    repeat (4) @(posedge clk); #2 rst_n = 1;
    repeat (4) @(posedge clk); #2;
    // R11 reset state
    chk(adc_convst == 0, "R11 convst", adc_convst, 0);
    chk(adc_cs_n == '1, "R11 chip selects", adc_cs_n, 7);
    chk(adc_sclk == 0, "R11 sclk", adc_sclk, 0);
    chk(ch_valid == 0, "R11 valid", ch_valid, 0);
    chk(overrun == 0, "R11 overrun", overrun, 0);
    chk(ch_val == '0, "R11 values", 0, 0);
    // R1 pulse without run control is ignored
    sample_pulse = 1; @(posedge clk); #2 sample_pulse = 0;
    repeat (600) @(posedge clk); #2;
    chk(n_conv == 0, "R1 no strobe when run off", n_conv, 0);
    chk(n_valid == 0, "R1 no valid when run off", n_valid, 0);
    chk(adc_cs_n == '1, "R1 no select when run off", adc_cs_n, 7);
    // ramp: distinct words per channel and per result
    for (int i = 0; i < NC; i++) begin
      cur_m[i] = 16'((i + 1) * 16'h0110 + 16'h0003);
      vol_m[i] = 16'(16'h8000 - (i + 1) * 16'h0230);
    end
    frame('0, 3, 0);
    frame('1, 0, 0);
    frame(12'hA5A, 12, 0);
    // R8 sign and cut boundaries
    for (int i = 0; i < NC; i++) begin
      case (i % 4)
        0: begin cur_m[i] = 16'h7FFF; vol_m[i] = 16'hFFF0; end
        1: begin cur_m[i] = 16'h8000; vol_m[i] = 16'h0010; end
        2: begin cur_m[i] = 16'hFFFF; vol_m[i] = 16'h800F; end
        default: begin cur_m[i] = 16'h000F; vol_m[i] = 16'h7FF0; end
      endcase
    end
    frame('0, 1, 0);
    frame('1, 40, 0);
    // random frames with random busy time
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NC; i++) begin
        cur_m[i] = 16'($urandom);
        vol_m[i] = 16'($urandom);
      end
      frame(NC'($urandom), int'($urandom % 31), 0);
    end
    // R10 pulse during a snapshot is dropped and flagged
    chk(overrun == 0, "R10 no overrun yet", overrun, 0);
    conv_before = n_conv; valid_before = n_valid;
    frame(12'h3C3, 20, 30);
    repeat (600) @(posedge clk); #2;
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    chk(n_conv == conv_before + 1, "R10 extra pulse starts nothing", n_conv, conv_before + 1);
    chk(n_valid == valid_before + 1, "R10 single snapshot", n_valid, valid_before + 1);
    frame(12'h0F0, 2, 0);
    chk(overrun == 1, "R10 overrun sticky", overrun, 1);
    chk(exp_q.size() == 0, "R9 every snapshot published", exp_q.size(), 0);
    finish_run();
  end

endmodule